// File: doc/BRIEF.md
# Indirect Register Window on an ISA-Style I/O Bus

This block sits between an ISA-style I/O bus and a 4K-byte internal register space, which holds 2048 words of 16 bits. The host does not address internal registers directly. It first loads a pointer register through a pointer port. It then moves data through one or two data ports, and each of these resolves to the word the pointer selects. When the pointer's advance flag is set, the pointer steps to the next word after each completed data access. A host can therefore stream a block of registers with one pointer write. For 32-bit transfers, data port 0 carries the low word and data port 1 carries the high word.

Three more ports in the 16-byte I/O window are shortcuts to fixed internal addresses: a transmit command word (0x144), a transmit length word (0x146) and an interrupt status queue word (0x120). The queue is modelled as a plain register. Internal address 0x138 is a read-only bus status word. Its bit 8 is a ready-for-transmit flag, which follows a command-then-length bid sequence so that a host can poll it.

Bus strobes are sampled on the block clock. A cycle is latched while a strobe is low. The cycle takes effect, as a register write or a pointer step, in the clock after both strobes have returned high.

Top module: `isa_regwin`

## Requirements
- R1: A bus cycle is accepted only when `aen` is 0 and `sa[15:4]` equals `IO_BASE[15:4]`. Outside that condition `sd_oe` stays 0 and a write changes nothing. `sd_oe` is 1 exactly when an accepted cycle has `ior_n` low.
- R2: Offset 0x0A (word offset; `sa[0]` is ignored throughout) is the pointer port. A read returns bit 15 = advance flag, bits 14..12 = tag, and bits 11..0 = byte address, each as last written.
- R3: The pointer tag field always reads 3'b011. Values written to bits 14..12 are discarded.
- R4: With the advance flag at 0, data port accesses leave the pointer unchanged.
- R5: With the advance flag at 1, each completed data port access (read or write) adds 2 to the 12-bit address, wrapping from 0xFFE to 0x000. The advance flag is kept.
- R6: Data port 0 (offset 0x08) reaches the word at the pointer address. Data port 1 (offset 0x0C) reaches pointer+2. The exception is the access that directly follows a completed advancing port-0 access: it reaches the pointer address itself, so that a low/high pair lands on two consecutive words.
- R7: Offset 0x04 reads and writes internal address 0x144. Offset 0x06 reads and writes internal address 0x146. These are the same words that the data ports reach.
- R8: Offset 0x0E reads internal address 0x120. A write to offset 0x0E is ignored.
- R9: Internal address 0x138 reads as 16'h0000 with bit 8 replaced by the ready flag. Writes to it are ignored.
- R10: A write to 0x146 that completes while a bid is open sets the ready flag one clock after the write takes effect. A write to 0x144 opens a bid and clears the flag. A write to 0x146 with no bid open leaves the flag unchanged.
- R11: Offsets 0x00 and 0x02 read 0, and writes to them have no effect.
- R12: After reset the pointer reads 16'h3000 and the ready flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa | input | 16 | Bus I/O address |
| aen | input | 1 | Address enable; 1 means a DMA cycle, so the bus cycle is not for this block |
| ior_n | input | 1 | Active-low read strobe |
| iow_n | input | 1 | Active-low write strobe |
| sd_in | input | 16 | Write data from the host |
| sd_out | output | 16 | Read data to the host, 0 when not driving |
| sd_oe | output | 1 | Read data valid, drive enable for the bus |

## Verification
The hardest situations to reach are the ones that depend on the history of completed accesses rather than on the current cycle. Examples are a port-1 access following an advancing port-0 access, a pointer wrapping at the top of the 12-bit space, and a length write arriving with no bid open. The stimulus reaches them through ordered sequences: a pointer load, then alternating port-0/port-1 accesses in both advance modes, then pointer readback. A length write is issued straight after reset, before any command write. Every stored word is later read back with a fixed pointer, so that a misplaced word shows up at the ports.

// File: rtl/isa_regwin_pkg.sv
package isa_regwin_pkg;

  localparam int ADDR_W = 12;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  typedef enum logic [2:0] {
    P_RSV0  = 3'd0,
    P_RSV1  = 3'd1,
    P_TXCMD = 3'd2,
    P_TXLEN = 3'd3,
    P_DATA0 = 3'd4,
    P_PTR   = 3'd5,
    P_DATA1 = 3'd6,
    P_ISQ   = 3'd7
  } port_e;

  localparam logic [ADDR_W-1:0] A_TXCMD = 12'h144;
  localparam logic [ADDR_W-1:0] A_TXLEN = 12'h146;
  localparam logic [ADDR_W-1:0] A_ISQ   = 12'h120;
  localparam logic [ADDR_W-1:0] A_BUSST = 12'h138;
  localparam logic [2:0]        PTR_TAG = 3'b011;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(2);
  endfunction

  function automatic logic [15:0] ptr_view(input logic adv, input logic [ADDR_W-1:0] a);
    return {adv, PTR_TAG, a};
  endfunction

  function automatic logic [ADDR_W-1:0] high_addr(input logic [ADDR_W-1:0] a,
                                                  input logic lo_adv);
    return lo_adv ? a : step_addr(a);
  endfunction

  function automatic logic [ADDR_W-1:0] port_target(input port_e p,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic lo_adv);
    case (p)
      P_TXCMD: return A_TXCMD;
      P_TXLEN: return A_TXLEN;
      P_ISQ:   return A_ISQ;
      P_DATA1: return high_addr(a, lo_adv);
      default: return a;
    endcase
  endfunction

  function automatic logic is_data(input port_e p);
    return (p == P_DATA0) || (p == P_DATA1);
  endfunction

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
  import isa_regwin_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'h0300
) (
  input  logic [15:0] sa,
  input  logic        aen,
  output logic        hit,
  output port_e       port
);
  localparam int WIN_LOG2 = 4;

  always_comb begin
    hit  = !aen && (sa[15:WIN_LOG2] == IO_BASE[15:WIN_LOG2]);
    port = port_e'(sa[WIN_LOG2-1:1]);
  end
endmodule

// File: rtl/isa_ptr_reg.sv
module isa_ptr_reg
  import isa_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              load,
  input  logic [15:0]       load_val,
  input  port_e             evt_port,
  output logic [ADDR_W-1:0] addr,
  output logic              adv,
  output logic              lo_adv
);
  logic data_evt;
  assign data_evt = evt && is_data(evt_port);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      adv    <= 1'b0;
      lo_adv <= 1'b0;
    end else if (load) begin
      addr   <= load_val[ADDR_W-1:0];
      adv    <= load_val[15];
      lo_adv <= 1'b0;
    end else if (evt) begin
      if (data_evt && adv) addr <= step_addr(addr);
      lo_adv <= adv && (evt_port == P_DATA0);
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !load && !adv) |=> (addr == $past(addr)));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !load && adv) |=> (addr == $past(addr) + 12'd2) && adv);
endmodule

// File: rtl/isa_reg_space.sv
module isa_reg_space
  import isa_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              tx_ready
);
  localparam int IDX_W = ADDR_W - 1;

  logic [15:0] mem [WORDS];
  logic bid_open, arm;
  logic cmd_wr, len_wr, status_wr;

  assign cmd_wr    = wr_en && (wr_addr[ADDR_W-1:1] == A_TXCMD[ADDR_W-1:1]);
  assign len_wr    = wr_en && (wr_addr[ADDR_W-1:1] == A_TXLEN[ADDR_W-1:1]);
  assign status_wr = wr_en && (wr_addr[ADDR_W-1:1] == A_BUSST[ADDR_W-1:1]);

  always_comb begin
    if (rd_addr[ADDR_W-1:1] == A_BUSST[ADDR_W-1:1])
      rd_data = {7'd0, tx_ready, 8'd0};
    else
      rd_data = mem[rd_addr[ADDR_W-1:1]];
  end

  always_ff @(posedge clk) begin
    if (wr_en && !status_wr) mem[wr_addr[ADDR_W-1:1]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bid_open <= 1'b0;
      arm      <= 1'b0;
      tx_ready <= 1'b0;
    end else begin
      arm <= len_wr && bid_open;
      if (cmd_wr) begin
        bid_open <= 1'b1;
        tx_ready <= 1'b0;
      end else begin
        if (len_wr) bid_open <= 1'b0;
        if (arm)    tx_ready <= 1'b1;
      end
    end
  end

  // R10
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && bid_open) |=> ##1 tx_ready);

  // R10
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !tx_ready);

  // R9
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[ADDR_W-1:1] == A_BUSST[ADDR_W-1:1]) |-> (rd_data[15:9] == 7'd0 && rd_data[7:0] == 8'd0));
endmodule

// File: rtl/isa_regwin.sv
module isa_regwin
  import isa_regwin_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'h0300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] sa,
  input  logic        aen,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic [15:0] sd_in,
  output logic [15:0] sd_out,
  output logic        sd_oe
);
  logic              hit;
  port_e             port;
  logic              strobe, act_q, cyc_hit, cyc_wr;
  port_e             cyc_port;
  logic [15:0]       cyc_data;
  logic              evt, ptr_load, rs_wr;
  logic [ADDR_W-1:0] ptr_addr, rd_addr, wr_addr;
  logic              ptr_adv, lo_adv;
  logic [15:0]       rd_data;

  isa_addr_decode #(.IO_BASE(IO_BASE)) u_dec (
    .sa(sa), .aen(aen), .hit(hit), .port(port)
  );

  assign strobe = !ior_n || !iow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cyc_hit  <= 1'b0;
      cyc_wr   <= 1'b0;
      cyc_port <= P_RSV0;
      cyc_data <= '0;
    end else begin
      act_q <= strobe;
      if (strobe) begin
        cyc_hit  <= hit;
        cyc_wr   <= !iow_n;
        cyc_port <= port;
        cyc_data <= sd_in;
      end else begin
        cyc_hit  <= 1'b0;
      end
    end
  end

  assign evt      = act_q && !strobe && cyc_hit;
  assign ptr_load = evt && cyc_wr && (cyc_port == P_PTR);
  assign rs_wr    = evt && cyc_wr &&
                    (is_data(cyc_port) || cyc_port == P_TXCMD || cyc_port == P_TXLEN);

  isa_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .evt(evt), .load(ptr_load), .load_val(cyc_data),
    .evt_port(cyc_port), .addr(ptr_addr), .adv(ptr_adv), .lo_adv(lo_adv)
  );

  assign rd_addr = port_target(port, ptr_addr, lo_adv);
  assign wr_addr = port_target(cyc_port, ptr_addr, lo_adv);

  isa_reg_space u_regs (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(rs_wr), .wr_addr(wr_addr), .wr_data(cyc_data), .tx_ready()
  );

  always_comb begin
    sd_oe  = hit && !ior_n;
    sd_out = '0;
    if (sd_oe) begin
      case (port)
        P_PTR:          sd_out = ptr_view(ptr_adv, ptr_addr);
        P_RSV0, P_RSV1: sd_out = '0;
        default:        sd_out = rd_data;
      endcase
    end
  end

  // R1
  oe_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (!aen && !ior_n));

  // R3
  ptr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && port == P_PTR) |-> (sd_out[14:12] == 3'b011));

  // R1
  miss_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !strobe && !cyc_hit) |=> (ptr_addr == $past(ptr_addr)));
endmodule

// File: tb/isa_regwin_test.sv
module isa_regwin_test;
  localparam logic [15:0] BASE = 16'h0300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] sa = '0;
  logic aen = 1'b1;
  logic ior_n = 1'b1;
  logic iow_n = 1'b1;
  logic [15:0] sd_in = '0;
  logic [15:0] sd_out;
  logic sd_oe;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  isa_regwin #(.IO_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic chk(input string rq, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [15:0] d, input logic en_high = 1'b0);
    @(negedge clk); sa = a; aen = en_high; sd_in = d; iow_n = 1'b0;
    @(negedge clk); @(negedge clk); iow_n = 1'b1;
    @(negedge clk); @(negedge clk); aen = 1'b1;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [15:0] d, output logic oe,
                       input logic en_high = 1'b0);
    @(negedge clk); sa = a; aen = en_high; ior_n = 1'b0;
    @(negedge clk); d = sd_out; oe = sd_oe;
    @(negedge clk); ior_n = 1'b1;
    @(negedge clk); @(negedge clk); aen = 1'b1;
  endtask

  function automatic logic [15:0] pview(input logic [15:0] w);
    return {w[15], 3'b011, w[11:0]};
  endfunction

  task automatic set_ptr(input logic [15:0] v);
    io_wr(BASE + 16'h0A, v);
  endtask

  task automatic rd_chk(input string rq, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d; logic oe;
    io_rd(a, d, oe);
    chk({rq, " oe"}, {15'd0, oe}, 16'd1);
    chk(rq, d, exp);
  endtask

  initial begin
    logic [15:0] d; logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd_chk("R12 ptr", BASE + 16'h0A, 16'h3000);
    set_ptr(16'h0138);
    rd_chk("R12 ready", BASE + 16'h08, 16'h0000);

    // R10 length write with no bid open leaves flag clear
    io_wr(BASE + 16'h06, 16'h0040);
    rd_chk("R10 no bid", BASE + 16'h08, 16'h0000);

    // R2 R3 pointer readback sweep over the upper nibble
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = {i[3:0], 12'h0A4 + 12'(i * 2)};
      set_ptr(v);
      rd_chk("R2 R3 ptr view", BASE + 16'h0A, pview(v));
    end

    // R5 R6 advancing port-0 stream
    set_ptr(16'h8100);
    for (int i = 0; i < 16; i++) io_wr(BASE + 16'h08, 16'hA000 + 16'(i));
    rd_chk("R5 ptr after stream", BASE + 16'h0A, 16'hB120);
    for (int i = 0; i < 16; i++) begin
      set_ptr(16'h0100 + 16'(2 * i));
      rd_chk("R6 stream word", BASE + 16'h08, 16'hA000 + 16'(i));
      rd_chk("R4 ptr fixed", BASE + 16'h0A, 16'h3100 + 16'(2 * i));
    end

    // R5 wrap at top of space
    set_ptr(16'h8FFE);
    io_wr(BASE + 16'h08, 16'h5A5A);
    rd_chk("R5 wrap", BASE + 16'h0A, 16'hB000);
    set_ptr(16'h0FFE);
    rd_chk("R5 wrap word", BASE + 16'h08, 16'h5A5A);

    // R6 advancing 32-bit pairs
    set_ptr(16'h8200);
    io_wr(BASE + 16'h08, 16'h1111);
    io_wr(BASE + 16'h0C, 16'h2222);
    io_wr(BASE + 16'h08, 16'h3333);
    io_wr(BASE + 16'h0C, 16'h4444);
    rd_chk("R5 ptr after pairs", BASE + 16'h0A, 16'hB208);
    set_ptr(16'h0200);
    rd_chk("R6 pair lo", BASE + 16'h08, 16'h1111);
    rd_chk("R6 pair hi", BASE + 16'h0C, 16'h2222);
    set_ptr(16'h0204);
    rd_chk("R6 pair2 lo", BASE + 16'h08, 16'h3333);
    rd_chk("R6 pair2 hi", BASE + 16'h0C, 16'h4444);
    set_ptr(16'h8200);
    rd_chk("R6 adv rd lo", BASE + 16'h08, 16'h1111);
    rd_chk("R6 adv rd hi", BASE + 16'h0C, 16'h2222);
    rd_chk("R5 ptr after rd pair", BASE + 16'h0A, 16'hB204);

    // R4 R6 fixed-pointer pair
    set_ptr(16'h0300);
    io_wr(BASE + 16'h08, 16'h7777);
    io_wr(BASE + 16'h0C, 16'h8888);
    rd_chk("R4 ptr kept", BASE + 16'h0A, 16'h3300);
    rd_chk("R6 fixed lo", BASE + 16'h08, 16'h7777);
    rd_chk("R6 fixed hi", BASE + 16'h0C, 16'h8888);

    // R7 shortcut aliases
    io_wr(BASE + 16'h04, 16'h00C9);
    set_ptr(16'h0144);
    rd_chk("R7 cmd alias", BASE + 16'h08, 16'h00C9);
    set_ptr(16'h0146);
    io_wr(BASE + 16'h08, 16'h05EA);
    rd_chk("R7 len alias", BASE + 16'h06, 16'h05EA);
    rd_chk("R7 cmd port rd", BASE + 16'h04, 16'h00C9);

    // R9 R10 bid then poll
    io_wr(BASE + 16'h04, 16'h00C0);
    set_ptr(16'h0138);
    rd_chk("R10 cleared by cmd", BASE + 16'h08, 16'h0000);
    io_wr(BASE + 16'h06, 16'h0100);
    rd_chk("R10 ready set", BASE + 16'h08, 16'h0100);
    io_wr(BASE + 16'h06, 16'h0080);
    rd_chk("R10 ready held", BASE + 16'h08, 16'h0100);
    io_wr(BASE + 16'h08, 16'hFFFF);
    rd_chk("R9 status write ignored", BASE + 16'h08, 16'h0100);
    io_wr(BASE + 16'h04, 16'h00C0);
    rd_chk("R10 cleared again", BASE + 16'h08, 16'h0000);

    // R8 status queue port
    set_ptr(16'h0120);
    io_wr(BASE + 16'h08, 16'h0F0F);
    rd_chk("R8 isq read", BASE + 16'h0E, 16'h0F0F);
    io_wr(BASE + 16'h0E, 16'h1234);
    rd_chk("R8 isq write ignored", BASE + 16'h0E, 16'h0F0F);
    rd_chk("R8 isq word kept", BASE + 16'h08, 16'h0F0F);

    // R11 reserved offsets
    io_wr(BASE + 16'h00, 16'hFFFF);
    io_wr(BASE + 16'h02, 16'hFFFF);
    rd_chk("R11 rsv0", BASE + 16'h00, 16'h0000);
    rd_chk("R11 rsv1", BASE + 16'h02, 16'h0000);
    rd_chk("R11 ptr untouched", BASE + 16'h0A, 16'h3120);
    rd_chk("R11 word untouched", BASE + 16'h08, 16'h0F0F);

    // R1 decode qualification
    io_wr(BASE + 16'h0A, 16'h8555, 1'b1);
    rd_chk("R1 aen write ignored", BASE + 16'h0A, 16'h3120);
    io_rd(BASE + 16'h0A, d, oe, 1'b1);
    chk("R1 aen read no oe", {15'd0, oe}, 16'd0);
    io_wr(BASE + 16'h1A, 16'h8555);
    io_wr(BASE - 16'h06, 16'h8555);
    rd_chk("R1 outside write ignored", BASE + 16'h0A, 16'h3120);
    io_rd(BASE + 16'h1A, d, oe);
    chk("R1 outside read no oe", {15'd0, oe}, 16'd0);
    chk("R1 outside read data", d, 16'h0000);
    rd_chk("R1 odd byte same word", BASE + 16'h0B, 16'h3120);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule